// File: doc/BRIEF.md
# Message-Signalled Interrupt File with Claim

This block is one privilege level's interrupt file in a message-signalled interrupt controller. It holds a pending bit and an enable bit for every interrupt identity. A message write that carries an identity sets that identity's pending bit. The block then picks, on every cycle, the highest-priority identity that is both pending and enabled. A smaller identity number has the higher priority.

The arbitration result is shown through a top-interrupt register. This register is live: it reports the newest result at every read, including a read made after the hart has trapped but before it claims. Software claims an interrupt with one access that reads and writes the top-interrupt register. That access clears the pending bit of the identity the same access reports.

A delivery-enable register controls only the interrupt line to the hart. It does not change the top-interrupt value, and it does not change how a claim works. All registers are reached through a single-cycle CSR-style port. A request with the write flag set is a read-and-write access, and its read data is the value before the write.

Top module: `msif_file`

## Requirements
- R1: After reset, all pending bits, enable bits and the delivery enable are zero. The top-interrupt register reads 0 and `irq_o` is low.
- R2: A message with `msg_valid` high sets the pending bit of `msg_id` at the next clock edge. Identity 0 is reserved and is ignored. Pending identity `i` reads at address 0x10 + i/32, bit i%32.
- R3: The top-interrupt register, at address 0x01, reads `(id << 16) | id`. Here `id` is the smallest identity that is both pending and enabled. It reads 0 when no identity is both pending and enabled.
- R4: The top-interrupt register holds no value latched at trap time. In the cycle after a higher-priority message is accepted, a read reports the newer identity.
- R5: A CSR access to address 0x01 with `csr_we` high returns the current top value. In the same cycle, it clears the pending bit of the identity that value reports.
- R6: A claim access while the top value is 0 leaves every pending bit unchanged.
- R7: If a message and a claim name the same identity in the same cycle, the message wins and the pending bit stays set.
- R8: Bit 0 of address 0x00 is the delivery enable. `irq_o` is high exactly when delivery is enabled and the top value is nonzero. Delivery enable has no effect on the top value or on claims.
- R9: Enable identity `i` is read and written at address 0x20 + i/32, bit i%32. The bit for identity 0 always reads 0.
- R10: A write to a pending word replaces those pending bits, and the identity 0 bit stays 0. A message in the same cycle still sets its own bit.
- R11: A read of address 0x01 with `csr_we` low changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming message write strobe |
| msg_id | input | ID_W (6) | Identity carried by the message |
| csr_req | input | 1 | Register access request |
| csr_we | input | 1 | Write flag; together with the read, this makes a read-and-write access |
| csr_addr | input | 8 | Register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational, showing state before the edge |
| irq_o | output | 1 | External interrupt line to the hart |

## Verification
A pending or enable bit held in the wrong state shows up in the same cycle in two places: the top-interrupt read and `irq_o`. It also shows in the pending or enable word at its address. A claim that clears the wrong identity leaves the cleared identity visible in the next top read. Losing a message that arrives at the same time as a claim shows one cycle later as a missing pending bit. The bench therefore reads back the top value and the word registers right after each action that changes state.

// File: rtl/msif_pkg.sv
package msif_pkg;

  localparam logic [7:0] ADDR_DELIV = 8'h00;
  localparam logic [7:0] ADDR_TOP   = 8'h01;
  localparam logic [3:0] PAGE_PEND  = 4'h1;
  localparam logic [3:0] PAGE_ENAB  = 4'h2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DELIV,
    SEL_TOP,
    SEL_PEND,
    SEL_ENAB
  } reg_sel_e;

  // Top-interrupt word: identity in the upper half, priority (equal to identity) in the lower half.
  function automatic logic [31:0] top_encode(input logic [15:0] id);
    return {id, id};
  endfunction

endpackage

// File: rtl/msif_store.sv
module msif_store #(
  parameter int NUM_IDS = 63,
  parameter int NWORDS  = 2,
  parameter int ID_W    = 6,
  parameter int WIDX_W  = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   msg_fire,
  input  logic [ID_W-1:0]        msg_id,
  input  logic                   claim_fire,
  input  logic [ID_W-1:0]        claim_id,
  input  logic                   pend_wr,
  input  logic                   en_wr,
  input  logic [WIDX_W-1:0]      wr_word,
  input  logic [31:0]            wr_data,
  output logic [NWORDS*32-1:0]   pend_q,
  output logic [NWORDS*32-1:0]   en_q
);
  localparam int NBITS = NWORDS * 32;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (i >= 1 && i <= NUM_IDS) begin : g_live
      logic set_hit;
      logic clr_hit;
      logic word_hit;
      assign set_hit  = msg_fire && (msg_id == ID_W'(i));
      assign clr_hit  = claim_fire && (claim_id == ID_W'(i));
      assign word_hit = (wr_word == WIDX_W'(i / 32));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q[i] <= 1'b0;
          en_q[i]   <= 1'b0;
        end else begin
          if (set_hit)                    pend_q[i] <= 1'b1;
          else if (pend_wr && word_hit)   pend_q[i] <= wr_data[i % 32];
          else if (clr_hit)               pend_q[i] <= 1'b0;
          if (en_wr && word_hit)          en_q[i]   <= wr_data[i % 32];
        end
      end
    end else begin : g_tie
      assign pend_q[i] = 1'b0;
      assign en_q[i]   = 1'b0;
    end
  end

  // R2 / R7 / R10: an accepted message always leaves its bit pending
  a_r2_msg_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_fire && msg_id != '0) |=> pend_q[$past(msg_id)]);

  // R5: a claim clears its identity unless a message for it arrives together
  a_r5_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && !(msg_fire && msg_id == claim_id)) |=> !pend_q[$past(claim_id)]);

endmodule

// File: rtl/msif_arbiter.sv
module msif_arbiter #(
  parameter int NUM_IDS = 63,
  parameter int NBITS   = 64,
  parameter int ID_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] pend_q,
  input  logic [NBITS-1:0] en_q,
  output logic [ID_W-1:0]  top_id,
  output logic             top_valid
);
  logic [NBITS-1:0] active;
  assign active = pend_q & en_q;

  // Smallest active identity wins: scan downward so the last hit is the lowest.
  function automatic logic [ID_W-1:0] lowest_active(input logic [NBITS-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = NUM_IDS; i >= 1; i--) begin
      if (v[i]) r = ID_W'(i);
    end
    return r;
  endfunction

  assign top_id    = lowest_active(active);
  assign top_valid = (top_id != '0);

  // R3: reported identity is really pending and enabled
  a_r3_top_live: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (pend_q[top_id] && en_q[top_id]));

  // R3: a zero report means nothing is both pending and enabled
  a_r3_none_active: assert property (@(posedge clk) disable iff (!rst_n)
    !top_valid |-> (active == '0));

endmodule

// File: rtl/msif_csr.sv
module msif_csr
  import msif_pkg::*;
#(
  parameter int NWORDS = 2,
  parameter int WIDX_W = 1
) (
  input  logic                  csr_req,
  input  logic                  csr_we,
  input  logic [7:0]            csr_addr,
  input  logic [31:0]           csr_wdata,
  input  logic [NWORDS*32-1:0]  pend_q,
  input  logic [NWORDS*32-1:0]  en_q,
  input  logic                  deliv_q,
  input  logic [31:0]           top_word,
  output logic [31:0]           csr_rdata,
  output logic                  deliv_wr,
  output logic                  pend_wr,
  output logic                  en_wr,
  output logic                  top_rw,
  output logic [WIDX_W-1:0]     wr_word
);
  reg_sel_e sel;
  logic     idx_ok;

  assign idx_ok  = (32'(csr_addr[3:0]) < NWORDS);
  assign wr_word = WIDX_W'(csr_addr[3:0]);

  always_comb begin
    sel = SEL_NONE;
    if (csr_addr == ADDR_DELIV)                     sel = SEL_DELIV;
    else if (csr_addr == ADDR_TOP)                  sel = SEL_TOP;
    else if (csr_addr[7:4] == PAGE_PEND && idx_ok)  sel = SEL_PEND;
    else if (csr_addr[7:4] == PAGE_ENAB && idx_ok)  sel = SEL_ENAB;
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_req) begin
      unique case (sel)
        SEL_DELIV: csr_rdata = {31'b0, deliv_q};
        SEL_TOP:   csr_rdata = top_word;
        SEL_PEND:  csr_rdata = pend_q[32*wr_word +: 32];
        SEL_ENAB:  csr_rdata = en_q[32*wr_word +: 32];
        default:   csr_rdata = '0;
      endcase
    end
  end

  assign deliv_wr = csr_req && csr_we && (sel == SEL_DELIV);
  assign top_rw   = csr_req && csr_we && (sel == SEL_TOP);
  assign pend_wr  = csr_req && csr_we && (sel == SEL_PEND);
  assign en_wr    = csr_req && csr_we && (sel == SEL_ENAB);

endmodule

// File: rtl/msif_file.sv
module msif_file
  import msif_pkg::*;
#(
  parameter int NUM_IDS = 63,
  localparam int ID_W   = $clog2(NUM_IDS + 1),
  localparam int NWORDS = (NUM_IDS + 1 + 31) / 32,
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msg_valid,
  input  logic [ID_W-1:0] msg_id,
  input  logic            csr_req,
  input  logic            csr_we,
  input  logic [7:0]      csr_addr,
  input  logic [31:0]     csr_wdata,
  output logic [31:0]     csr_rdata,
  output logic            irq_o
);
  localparam int NBITS = NWORDS * 32;

  logic [NBITS-1:0]  pend_q, en_q;
  logic [ID_W-1:0]   top_id;
  logic              top_valid;
  logic [31:0]       top_word;
  logic              deliv_q;
  logic              deliv_wr, pend_wr, en_wr, top_rw;
  logic [WIDX_W-1:0] wr_word;
  logic              claim_fire;
  logic              msg_fire;

  assign msg_fire   = msg_valid && (msg_id != '0) && (32'(msg_id) <= NUM_IDS);
  assign claim_fire = top_rw && top_valid;
  assign top_word   = top_encode(16'(top_id));

  msif_store #(.NUM_IDS(NUM_IDS), .NWORDS(NWORDS), .ID_W(ID_W), .WIDX_W(WIDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .msg_fire(msg_fire), .msg_id(msg_id),
    .claim_fire(claim_fire), .claim_id(top_id),
    .pend_wr(pend_wr), .en_wr(en_wr), .wr_word(wr_word), .wr_data(csr_wdata),
    .pend_q(pend_q), .en_q(en_q)
  );

  msif_arbiter #(.NUM_IDS(NUM_IDS), .NBITS(NBITS), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .pend_q(pend_q), .en_q(en_q),
    .top_id(top_id), .top_valid(top_valid)
  );

  msif_csr #(.NWORDS(NWORDS), .WIDX_W(WIDX_W)) u_csr (
    .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .pend_q(pend_q), .en_q(en_q), .deliv_q(deliv_q), .top_word(top_word),
    .csr_rdata(csr_rdata),
    .deliv_wr(deliv_wr), .pend_wr(pend_wr), .en_wr(en_wr), .top_rw(top_rw), .wr_word(wr_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        deliv_q <= 1'b0;
    else if (deliv_wr) deliv_q <= csr_wdata[0];
  end

  // Delivery gates only the hart line.
  assign irq_o = deliv_q && top_valid;

  // R6: a claim with nothing to report leaves pending state alone
  a_r6_idle_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (top_rw && !top_valid && !msg_valid) |=> $stable(pend_q));

  // R11: a plain read of the top register leaves pending state alone
  a_r11_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && !csr_we && csr_addr == ADDR_TOP && !msg_valid) |=> $stable(pend_q));

  // R8: the hart line rises only while delivery is on
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> deliv_q);

endmodule

// File: tb/tb_msif_file.sv
module tb_msif_file;
  localparam int NV = 43;
  localparam logic [3:0] OP_MSG = 4'd0, OP_WR = 4'd1, OP_RD = 4'd2, OP_CL = 4'd3, OP_IQ = 4'd4;

  // {op, requirement, addr, data, expected}
  localparam logic [79:0] VEC [NV] = '{
    {OP_RD,  4'd1,  8'h01, 32'h0,        32'h0},        // R1
    {OP_IQ,  4'd1,  8'h00, 32'h0,        32'h0},        // R1
    {OP_WR,  4'd9,  8'h20, 32'hFFFFFFFF, 32'h0},        // R9
    {OP_RD,  4'd9,  8'h20, 32'h0,        32'hFFFFFFFE}, // R9 id0 stays 0
    {OP_WR,  4'd9,  8'h21, 32'h000000FF, 32'h0},
    {OP_RD,  4'd9,  8'h21, 32'h0,        32'h000000FF},
    {OP_MSG, 4'd2,  8'h00, 32'd40,       32'h0},        // R2 id40 not enabled
    {OP_RD,  4'd3,  8'h01, 32'h0,        32'h0},        // R3
    {OP_RD,  4'd2,  8'h11, 32'h0,        32'h00000100},
    {OP_MSG, 4'd2,  8'h00, 32'd4,        32'h0},
    {OP_RD,  4'd3,  8'h01, 32'h0,        32'h00040004},
    {OP_MSG, 4'd4,  8'h00, 32'd1,        32'h0},        // R4 newer, higher
    {OP_RD,  4'd4,  8'h01, 32'h0,        32'h00010001},
    {OP_IQ,  4'd8,  8'h00, 32'h0,        32'h0},        // R8
    {OP_WR,  4'd8,  8'h00, 32'h1,        32'h0},
    {OP_RD,  4'd8,  8'h00, 32'h0,        32'h1},
    {OP_IQ,  4'd8,  8'h00, 32'h0,        32'h1},
    {OP_CL,  4'd5,  8'h01, 32'h0,        32'h00010001}, // R5
    {OP_RD,  4'd5,  8'h01, 32'h0,        32'h00040004},
    {OP_RD,  4'd5,  8'h10, 32'h0,        32'h00000010},
    {OP_CL,  4'd5,  8'h01, 32'h0,        32'h00040004},
    {OP_RD,  4'd3,  8'h01, 32'h0,        32'h0},
    {OP_IQ,  4'd8,  8'h00, 32'h0,        32'h0},
    {OP_CL,  4'd6,  8'h01, 32'h0,        32'h0},        // R6
    {OP_RD,  4'd6,  8'h11, 32'h0,        32'h00000100},
    {OP_MSG, 4'd2,  8'h00, 32'd0,        32'h0},        // R2 reserved id
    {OP_RD,  4'd2,  8'h10, 32'h0,        32'h0},
    {OP_WR,  4'd8,  8'h00, 32'h0,        32'h0},
    {OP_MSG, 4'd8,  8'h00, 32'd35,       32'h0},
    {OP_RD,  4'd8,  8'h01, 32'h0,        32'h00230023}, // R8 no effect on top
    {OP_IQ,  4'd8,  8'h00, 32'h0,        32'h0},
    {OP_CL,  4'd8,  8'h01, 32'h0,        32'h00230023},
    {OP_RD,  4'd8,  8'h11, 32'h0,        32'h00000100},
    {OP_WR,  4'd10, 8'h10, 32'hFFFFFFFF, 32'h0},        // R10
    {OP_RD,  4'd10, 8'h10, 32'h0,        32'hFFFFFFFE},
    {OP_RD,  4'd3,  8'h01, 32'h0,        32'h00010001},
    {OP_WR,  4'd10, 8'h10, 32'h0,        32'h0},
    {OP_RD,  4'd10, 8'h10, 32'h0,        32'h0},
    {OP_MSG, 4'd11, 8'h00, 32'd2,        32'h0},        // R11
    {OP_RD,  4'd11, 8'h01, 32'h0,        32'h00020002},
    {OP_RD,  4'd11, 8'h01, 32'h0,        32'h00020002},
    {OP_RD,  4'd11, 8'h10, 32'h0,        32'h00000004},
    {OP_CL,  4'd11, 8'h01, 32'h0,        32'h00020002}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [5:0]  msg_id = '0;
  logic        csr_req = 1'b0;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msif_file dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_id(msg_id),
    .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .irq_o(irq_o)
  );

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    msg_valid = 1'b0; msg_id = '0;
    csr_req = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
  endtask

  task automatic step(input logic [3:0] op, input int req, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] e);
    @(negedge clk);
    case (op)
      OP_MSG: begin msg_valid = 1'b1; msg_id = d[5:0]; end
      OP_WR:  begin csr_req = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d; end
      OP_RD:  begin csr_req = 1'b1; csr_we = 1'b0; csr_addr = a; end
      OP_CL:  begin csr_req = 1'b1; csr_we = 1'b1; csr_addr = 8'h01; csr_wdata = d; end
      default: ;
    endcase
    #1;
    if (op == OP_RD || op == OP_CL) check(req, csr_rdata, e);
    if (op == OP_IQ) check(req, {31'b0, irq_o}, e);
    @(posedge clk);
    #1 idle_inputs();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][79:76], int'(VEC[k][75:72]), VEC[k][71:64], VEC[k][63:32], VEC[k][31:0]);
    end

    // R7: a message and a claim for the same identity in the same cycle
    step(OP_MSG, 7, 8'h00, 32'd3, 32'h0);
    @(negedge clk);
    msg_valid = 1'b1; msg_id = 6'd3;
    csr_req = 1'b1; csr_we = 1'b1; csr_addr = 8'h01;
    #1 check(7, csr_rdata, 32'h00030003);
    @(posedge clk);
    #1 idle_inputs();
    step(OP_RD, 7, 8'h10, 32'h0, 32'h00000008);   // R7 bit stays set

    // R10: a pending-word write in the same cycle as a message for id5
    @(negedge clk);
    msg_valid = 1'b1; msg_id = 6'd5;
    csr_req = 1'b1; csr_we = 1'b1; csr_addr = 8'h10; csr_wdata = 32'h0;
    @(posedge clk);
    #1 idle_inputs();
    step(OP_RD, 10, 8'h10, 32'h0, 32'h00000020);

    // R1: reset in the middle of activity
    step(OP_WR, 1, 8'h00, 32'h1, 32'h0);
    step(OP_IQ, 1, 8'h00, 32'h0, 32'h1);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    step(OP_RD, 1, 8'h01, 32'h0, 32'h0);
    step(OP_RD, 1, 8'h10, 32'h0, 32'h0);
    step(OP_RD, 1, 8'h20, 32'h0, 32'h0);
    step(OP_RD, 1, 8'h00, 32'h0, 32'h0);
    step(OP_IQ, 1, 8'h00, 32'h0, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule